// File: doc/BRIEF.md
# Scaled Floating-Point Rounding Unit

This unit takes one single-precision floating-point operand and keeps a chosen number of binary fraction bits, from 0 to 15. It multiplies the operand by 2^M, rounds that product to an integer, and scales the result back by 2^-M. The scaling works as if the exponent range had no limit. An 8-bit control byte sets M, the rounding mode, where the mode comes from, and whether the precision flag is muted.

The unit has a registered output and a one-cycle latency. Each accepted operand produces a result, an invalid flag and a precision flag on the next clock. It handles NaNs, infinities, signed zeros and denormals itself, so a vector datapath can place one copy per lane with no extra logic around it.

Top module: `fp_scale_round`

## Requirements
- R1: A result appears one clock after `in_valid` is sampled high, and `out_valid` is high in that cycle only. A cycle with `in_valid` low gives `out_valid` low on the next clock. Synchronous reset clears `out_valid`, `result` and both flags to 0.
- R2: `ctrl[7:4]` gives M. The result equals 2^-M × round(x × 2^M). An operand that already has no more than M fraction bits (unbiased exponent ≥ 23 − M) comes back bit-exact with no flags raised.
- R3: The mode code is 00 for nearest with ties to even, 01 for toward minus infinity, 10 for toward plus infinity and 11 for toward zero. For example, 2.5 with M=0 gives 2.0, 2.0, 3.0 and 2.0.
- R4: With `ctrl[2]`=1 the mode is taken from `ext_mode`. With `ctrl[2]`=0 it is taken from `ctrl[1:0]`.
- R5: No overflow is possible. A finite input never gives an all-ones exponent. When the rounding carries out of the significand, the exponent goes up by one and the fraction becomes zero (3.5 rounded to nearest with M=0 gives 4.0).
- R6: With `ctrl[3]`=0, `flag_inexact` is high exactly when the result differs from the operand. With `ctrl[3]`=1, `flag_inexact` is always low.
- R7: A signalling NaN (all-ones exponent, fraction bit 22 clear, fraction non-zero) comes back with fraction bit 22 set and all other bits kept, and it raises `flag_invalid`. No other input raises `flag_invalid`.
- R8: Quiet NaNs (fraction bit 22 set) and infinities come back unchanged with no flags.
- R9: With `daz_en`=1, a denormal input is treated as a zero of the same sign. The result is that signed zero with no flags. With `daz_en`=0, a denormal is rounded like any other tiny value.
- R10: The sign of every non-NaN result equals the sign of the operand, and this includes zero results.
- R11: When the magnitude is below 2^-M, the result is a signed zero or a signed 2^-M. Nearest mode gives 2^-M only above 2^-(M+1), so an exact tie goes to zero. Toward-zero mode gives zero. A directed mode gives 2^-M only when the operand's sign points in that direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand and controls are valid this cycle |
| operand | input | 32 | Single-precision input value |
| ctrl | input | 8 | [7:4] M, [3] mute precision flag, [2] mode source, [1:0] mode |
| ext_mode | input | 2 | Rounding mode used when ctrl[2] is set |
| daz_en | input | 1 | Treat denormal inputs as signed zero |
| out_valid | output | 1 | Result registers hold a new result |
| result | output | 32 | Rounded single-precision value |
| flag_invalid | output | 1 | Signalling NaN was quieted |
| flag_inexact | output | 1 | Result differs from input (unless muted) |

## Verification
Every result, and both flags, comes due exactly one clock edge after the edge that sampled `in_valid`. The bench drives its stimulus on falling edges. For each drive, including idle ones, it pushes the expected entry onto a queue. On the next falling edge it pops that entry and compares it with the outputs. A bubble is therefore checked as `out_valid` low on the cycle it is due, and a result is never compared one cycle early or late.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;

  typedef enum logic [1:0] {
    RND_NEAR_EVEN = 2'b00,
    RND_DOWN      = 2'b01,
    RND_UP        = 2'b10,
    RND_ZERO      = 2'b11
  } rnd_mode_e;

  // control byte bit positions below the scale field
  localparam int CB_MUTE = 3;
  localparam int CB_SRC  = 2;

  typedef struct packed {
    logic sign;
    logic is_zero;
    logic is_sub;
    logic is_inf;
    logic is_qnan;
    logic is_snan;
  } fp_class_t;

endpackage

// File: rtl/fpsr_unpack.sv
module fpsr_unpack
  import fpsr_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W,
  localparam int SIG_W = FRAC_W + 1
) (
  input  logic [W-1:0]     operand,
  input  logic             daz_en,
  output fp_class_t        cls,
  output logic [EXP_W-1:0] exp_eff,
  output logic [SIG_W-1:0] sig
);

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic exp_max, exp_min, frac_nz;

  always_comb begin
    exp_f   = operand[W-2:FRAC_W];
    frac_f  = operand[FRAC_W-1:0];
    exp_max = &exp_f;
    exp_min = ~|exp_f;
    frac_nz = |frac_f;

    cls.sign    = operand[W-1];
    cls.is_inf  = exp_max && !frac_nz;
    cls.is_qnan = exp_max && frac_f[FRAC_W-1];
    cls.is_snan = exp_max && frac_nz && !frac_f[FRAC_W-1];
    cls.is_sub  = exp_min && frac_nz && !daz_en;
    cls.is_zero = exp_min && (!frac_nz || daz_en);

    // denormals share the exponent of the smallest normal, no hidden one
    exp_eff = exp_min ? EXP_W'(1) : exp_f;
    sig     = {!exp_min, frac_f};
  end

endmodule

// File: rtl/fpsr_mode_pick.sv
module fpsr_mode_pick
  import fpsr_pkg::*;
(
  input  logic      src_ext,
  input  logic [1:0] imm_mode,
  input  logic [1:0] ext_mode,
  output rnd_mode_e mode
);

  always_comb begin
    mode = rnd_mode_e'(src_ext ? ext_mode : imm_mode);
  end

endmodule

// File: rtl/fpsr_round_path.sv
module fpsr_round_path
  import fpsr_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int SCL_W  = 4,
  localparam int W     = 1 + EXP_W + FRAC_W,
  localparam int SIG_W = FRAC_W + 1,
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1,
  localparam int XW    = EXP_W + SCL_W + 3,
  localparam int SHW   = $clog2(SIG_W + 1)
) (
  input  logic [W-1:0]     operand,
  input  fp_class_t        cls,
  input  logic [EXP_W-1:0] exp_eff,
  input  logic [SIG_W-1:0] sig,
  input  logic [SCL_W-1:0] scale,
  input  rnd_mode_e        mode,
  output logic [W-1:0]     res,
  output logic             inexact,
  output logic             invalid
);

  // number of significand bits that fall below the kept point
  logic signed [XW-1:0] drop_s;
  logic [SHW-1:0]       dsh;
  logic is_exact, is_tiny;
  logic [SIG_W-1:0] inc, half, kept, sum;
  logic lsb, rbit, sticky, lost;
  logic up_norm, up_tiny;
  logic [EXP_W-1:0] exp_in, unit_exp, exp_out;

  always_comb begin
    drop_s   = XW'(FRAC_W + BIAS) - XW'(exp_eff) - XW'(scale);
    is_exact = (drop_s <= 0) || cls.is_zero;
    is_tiny  = !is_exact && (drop_s > FRAC_W);
    dsh      = drop_s[SHW-1:0];

    inc    = SIG_W'(1) << dsh;
    half   = inc >> 1;
    kept   = sig & ~(inc - SIG_W'(1));
    lsb    = |(sig & inc);
    rbit   = |(sig & half);
    sticky = |(sig & (half - SIG_W'(1)));
    lost   = rbit | sticky;

    unique case (mode)
      RND_NEAR_EVEN: up_norm = rbit && (sticky || lsb);
      RND_DOWN:      up_norm = lost && cls.sign;
      RND_UP:        up_norm = lost && !cls.sign;
      default:       up_norm = 1'b0;
    endcase

    // below 2^-M: only the half-unit comparison matters for nearest
    unique case (mode)
      RND_NEAR_EVEN: up_tiny = (drop_s == XW'(FRAC_W + 1)) && !cls.is_sub
                               && (|sig[FRAC_W-1:0]);
      RND_DOWN:      up_tiny = cls.sign;
      RND_UP:        up_tiny = !cls.sign;
      default:       up_tiny = 1'b0;
    endcase

    sum      = up_norm ? (kept + inc) : kept;
    exp_in   = operand[W-2:FRAC_W];
    exp_out  = exp_in + EXP_W'(!sum[FRAC_W]);
    unit_exp = EXP_W'(BIAS) - EXP_W'(scale);
  end

  always_comb begin
    invalid = 1'b0;
    inexact = 1'b0;
    if (cls.is_snan) begin
      res     = operand | (W'(1) << (FRAC_W - 1));
      invalid = 1'b1;
    end else if (cls.is_inf || cls.is_qnan) begin
      res = operand;
    end else if (cls.is_zero) begin
      res = {cls.sign, {(W-1){1'b0}}};
    end else if (is_exact) begin
      res = operand;
    end else if (is_tiny) begin
      inexact = 1'b1;
      res     = up_tiny ? {cls.sign, unit_exp, {FRAC_W{1'b0}}}
                        : {cls.sign, {(W-1){1'b0}}};
    end else begin
      inexact = lost;
      res     = {cls.sign, exp_out, sum[FRAC_W-1:0]};
    end
  end

endmodule

// File: rtl/fp_scale_round.sv
module fp_scale_round
  import fpsr_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int SCL_W  = 4,
  localparam int W      = 1 + EXP_W + FRAC_W,
  localparam int SIG_W  = FRAC_W + 1,
  localparam int CTRL_W = SCL_W + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [W-1:0]      operand,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [1:0]        ext_mode,
  input  logic              daz_en,
  output logic              out_valid,
  output logic [W-1:0]      result,
  output logic              flag_invalid,
  output logic              flag_inexact
);

  fp_class_t        cls;
  logic [EXP_W-1:0] exp_eff;
  logic [SIG_W-1:0] sig;
  rnd_mode_e        mode;
  logic [W-1:0]     res_c;
  logic             inexact_c, invalid_c;

  fpsr_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
    .operand (operand),
    .daz_en  (daz_en),
    .cls     (cls),
    .exp_eff (exp_eff),
    .sig     (sig)
  );

  fpsr_mode_pick u_mode (
    .src_ext  (ctrl[CB_SRC]),
    .imm_mode (ctrl[1:0]),
    .ext_mode (ext_mode),
    .mode     (mode)
  );

  fpsr_round_path #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .SCL_W(SCL_W)) u_round (
    .operand (operand),
    .cls     (cls),
    .exp_eff (exp_eff),
    .sig     (sig),
    .scale   (ctrl[CTRL_W-1 -: SCL_W]),
    .mode    (mode),
    .res     (res_c),
    .inexact (inexact_c),
    .invalid (invalid_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      result       <= '0;
      flag_invalid <= 1'b0;
      flag_inexact <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result       <= res_c;
        flag_invalid <= invalid_c;
        flag_inexact <= inexact_c && !ctrl[CB_MUTE];
      end
    end
  end

endmodule

// File: rtl/fpsr_chk.sv
module fpsr_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int SCL_W  = 4,
  localparam int W      = 1 + EXP_W + FRAC_W,
  localparam int CTRL_W = SCL_W + 4,
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [W-1:0]      operand,
  input logic [CTRL_W-1:0] ctrl,
  input logic              out_valid,
  input logic [W-1:0]      result,
  input logic              flag_invalid,
  input logic              flag_inexact
);

  logic in_special, in_snan, in_fits;

  always_comb begin
    in_special = &operand[W-2:FRAC_W];
    in_snan    = in_special && !operand[FRAC_W-1] && (|operand[FRAC_W-1:0]);
    in_fits    = !in_special && (|operand[W-2:FRAC_W]) &&
                 (int'(operand[W-2:FRAC_W]) >= BIAS + FRAC_W - int'(ctrl[CTRL_W-1 -: SCL_W]));
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_bubble_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_fits_exact_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_fits |=> (result == $past(operand)) && !flag_inexact);
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    in_valid && !in_special |=> !(&result[W-2:FRAC_W]));
  p_mute_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid && ctrl[3] |=> !flag_inexact);
  p_snan_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_snan |=> flag_invalid && result[FRAC_W-1]);
  p_invalid_only_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid && !in_snan |=> !flag_invalid);
  p_special_pass_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_special && !in_snan |=> (result == $past(operand)) && !flag_inexact);
  p_sign_keep_r10: assert property (@(posedge clk) disable iff (rst)
    in_valid && !in_special |=> result[W-1] == $past(operand[W-1]));

endmodule

bind fp_scale_round fpsr_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .SCL_W(SCL_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .operand      (operand),
  .ctrl         (ctrl),
  .out_valid    (out_valid),
  .result       (result),
  .flag_invalid (flag_invalid),
  .flag_inexact (flag_inexact)
);

// File: tb/fp_scale_round_test.sv
module fp_scale_round_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] operand = '0;
  logic [7:0]  ctrl = '0;
  logic [1:0]  ext_mode = '0;
  logic        daz_en = 1'b0;
  logic        out_valid;
  logic [31:0] result;
  logic        flag_invalid, flag_inexact;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // expected entry: {valid, invalid, inexact, result}
  logic [34:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  fp_scale_round uut (
    .clk (clk), .rst (rst), .in_valid (in_valid), .operand (operand),
    .ctrl (ctrl), .ext_mode (ext_mode), .daz_en (daz_en),
    .out_valid (out_valid), .result (result),
    .flag_invalid (flag_invalid), .flag_inexact (flag_inexact)
  );

  // behavioural reference: integer arithmetic on the scaled value
  function automatic logic [33:0] model(input logic [31:0] x, input logic [7:0] c,
                                        input logic [1:0] em, input bit daz);
    bit s = x[31];
    int e = int'(x[30:23]);
    logic [22:0] f = x[22:0];
    int m = int'(c[7:4]);
    logic [1:0] md = c[2] ? em : c[1:0];
    longint unsigned sg, q, rem, half;
    int ex, k, cmp, p, rexp;
    bit inx, up;
    logic [31:0] r;
    if (e == 255) begin
      if (f != 0 && !f[22]) return {1'b1, 1'b0, s, 8'hFF, 1'b1, f[21:0]};
      return {2'b00, x};
    end
    if (e == 0 && (f == 0 || daz)) return {2'b00, s, 31'b0};
    if (e == 0) begin sg = longint'(f); ex = -126; end
    else begin sg = longint'({1'b1, f}); ex = e - 127; end
    k = 23 - ex - m;
    if (k <= 0) return {2'b00, x};
    if (k >= 62) begin q = 0; rem = sg; cmp = -1; end
    else begin
      q = sg >> k;
      rem = sg - (q << k);
      half = 64'd1 << (k - 1);
      cmp = (rem < half) ? -1 : (rem == half) ? 0 : 1;
    end
    inx = (rem != 0);
    case (md)
      2'b00: up = (cmp > 0) || (cmp == 0 && q[0]);
      2'b01: up = inx && s;
      2'b10: up = inx && !s;
      default: up = 1'b0;
    endcase
    q = q + longint'(up);
    if (q == 0) r = {s, 31'b0};
    else begin
      p = 0;
      for (int b = 0; b < 25; b++) if (q[b]) p = b;
      rexp = p - m + 127;
      r = {s, rexp[7:0], 23'((q << (23 - p)) & 64'h7FFFFF)};
    end
    return {1'b0, inx && !c[3], r};
  endfunction

  task automatic check_due();
    logic [34:0] e;
    string t;
    if (exp_q.size() == 0) return;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    checks++;
    if (out_valid !== e[34]) begin
      failures++;
      $display("FAIL %s out_valid actual=%0b expected=%0b", t, out_valid, e[34]);
    end else if (e[34] && {flag_invalid, flag_inexact, result} !== e[33:0]) begin
      failures++;
      $display("FAIL %s inv/inx/result actual=%0b/%0b/%08h expected=%0b/%0b/%08h",
               t, flag_invalid, flag_inexact, result, e[33], e[32], e[31:0]);
    end
  endtask

  task automatic drive(input logic v, input logic [31:0] x, input logic [7:0] c,
                       input logic [1:0] em, input bit dz, input string t);
    @(negedge clk);
    check_due();
    in_valid = v; operand = x; ctrl = c; ext_mode = em; daz_en = dz;
    exp_q.push_back(v ? {1'b1, model(x, c, em, dz)} : 35'd0);
    tag_q.push_back(t);
  endtask

  function automatic string cat_of(input logic [31:0] x, input logic [7:0] c, input bit dz);
    int e = int'(x[30:23]);
    if (e == 255) return (x[22] || x[22:0] == 0) ? "R8" : "R7";
    if (e == 0) return dz ? "R9" : "R11";
    if (e - 127 >= 23 - int'(c[7:4])) return "R2";
    if (e - 127 < -int'(c[7:4])) return "R11";
    if (c[3]) return "R6";
    return c[2] ? "R4" : "R3";
  endfunction

  initial begin
    #(4 * 150000);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] x;
    logic [7:0]  c;
    repeat (3) @(negedge clk);
    checks++;
    if ({out_valid, flag_invalid, flag_inexact, result} !== 35'd0) begin
      failures++;
      $display("FAIL R1 reset state actual=%0b%0b%0b/%08h expected=000/00000000",
               out_valid, flag_invalid, flag_inexact, result);
    end
    @(negedge clk); rst = 1'b0;

    // R3: 2.5 at M=0 under every mode
    drive(1, 32'h40200000, 8'h00, 2'b00, 0, "R3 near tie even");
    drive(1, 32'h40200000, 8'h01, 2'b00, 0, "R3 toward minus");
    drive(1, 32'h40200000, 8'h02, 2'b00, 0, "R3 toward plus");
    drive(1, 32'hC0200000, 8'h03, 2'b00, 0, "R3 toward zero");
    drive(0, 32'h0, 8'h00, 2'b00, 0, "R1 bubble");
    drive(1, 32'h40600000, 8'h00, 2'b00, 0, "R5 carry to 4.0");
    drive(1, 32'h3FA00000, 8'h10, 2'b00, 0, "R2 M=1 tie");
    drive(1, 32'h3FA00000, 8'h20, 2'b00, 0, "R2 M=2 exact");
    drive(1, 32'h4B000001, 8'hF0, 2'b00, 0, "R2 large M=15");
    drive(1, 32'h7F7FFFFF, 8'hF2, 2'b00, 0, "R5 max finite M=15");
    drive(1, 32'h40200000, 8'h04, 2'b10, 0, "R4 external plus");
    drive(1, 32'h40200000, 8'h06, 2'b00, 0, "R4 external near");
    drive(1, 32'h40200000, 8'h08, 2'b00, 0, "R6 muted");
    drive(1, 32'h7F800001, 8'h00, 2'b00, 0, "R7 snan");
    drive(1, 32'hFFC00123, 8'h00, 2'b00, 0, "R8 qnan");
    drive(1, 32'hFF800000, 8'h31, 2'b00, 0, "R8 minus inf");
    drive(1, 32'h80000005, 8'h02, 2'b00, 1, "R9 daz neg denorm");
    drive(1, 32'h80000005, 8'h02, 2'b00, 0, "R9 no daz");
    drive(1, 32'h00000005, 8'h02, 2'b00, 0, "R11 denorm up");
    drive(1, 32'hBE99999A, 8'h00, 2'b00, 0, "R10 minus zero");
    drive(1, 32'h3DCCCCCD, 8'h30, 2'b00, 0, "R11 up to 2^-3");
    drive(1, 32'h3D800000, 8'h30, 2'b00, 0, "R11 tie to zero");
    drive(1, 32'hBD800000, 8'h31, 2'b00, 0, "R11 neg toward minus");
    drive(1, 32'h80000000, 8'h00, 2'b00, 0, "R10 minus zero in");

    for (int i = 0; i < 4000; i++) begin
      x = $urandom;
      if ($urandom % 4 != 0) x[30:23] = 8'(100 + $urandom % 60);
      c = 8'($urandom);
      drive(($urandom % 8) != 0, x, c, 2'($urandom), ($urandom % 2) == 1, cat_of(x, c, 1'b0));
    end
    drive(0, 32'h0, 8'h00, 2'b00, 0, "R1 drain");
    @(negedge clk);
    check_due();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule